// File: doc/BRIEF.md
# ADPCM Sample Memory Address Sequencer

This block walks a byte-wide sample memory one 4-bit nibble at a time for a playback decoder. Software programs a start, an end and an optional wrap (limit) address as 16-bit values. It also selects a memory kind, which sets how far those values are scaled up to byte addresses. A control write then launches playback. From that point the decoder asks for one nibble at a time. The sequencer fetches a new byte from memory on every even nibble position. It hands out the high half first and the low half of the same byte next.

The running position is a nibble counter one bit wider than the byte address. When that counter reaches the end position, the sequencer behaves in one of two ways. If looping is enabled, it jumps back to the start and tells the decoder to restart its state. If looping is not enabled, it stops, drops busy and raises a sticky end-of-sample flag. A separately programmed limit position sends the counter back to zero, which lets a sample span the top of a smaller memory.

Top module: `adpcm_seq_top`

## Requirements
- R1: After reset, busy, eos, nib_valid and mem_rd_en are all 0, the memory kind is 1-bit DRAM (code 0), and the limit is disabled: its byte value is all ones, so no wrap happens until the limit register is written.
- R2: Register writes use select codes 0 for start, 1 for end, 2 for limit, 3 for memory kind (bits 1:0) and 4 for control. Kind code 0 scales a programmed value by a left shift of 2. Codes 1, 2 and 3 scale it by a left shift of 5. The first byte fetched after a start command is the scaled start address.
- R3: The end byte address is the scaled end value with all shifted-in low bits set to one. Playback stops when the nibble position equals twice this value (an equality test), so the last nibble played comes from the byte just before it.
- R4: At an even nibble position, the byte at position/2 is read and its bits 7:4 are returned. At an odd position, bits 3:0 of the held byte are returned with no memory read.
- R5: A read has a fixed one-cycle latency. A request accepted on a clock edge returns nib_valid one edge later for an odd position and three edges later for an even position. nib_valid and mem_rd_en are single-cycle pulses.
- R6: A request at the end position with looping off returns no nibble, sets eos and clears busy.
- R7: A request at the end position with looping on reloads the start position. It returns that byte's high nibble with nib_restart high. nib_restart is low on all other nibbles.
- R8: When the position equals twice the scaled limit, it becomes 0 before the end test and the fetch.
- R9: A control write with bit 2 set clears busy and the loop setting, abandons any fetch, and takes priority over bit 0.
- R10: A control write with bit 0 set raises busy, clears eos, loads the start position, and takes the loop setting from bit 1.
- R11: A nibble request while not busy causes no memory read and no nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | REG_W | Register write value |
| nib_req | input | 1 | Request for the next nibble |
| nib_valid | output | 1 | Nibble output valid pulse |
| nib_data | output | 4 | Nibble value |
| nib_restart | output | 1 | Decoder restart marker, sent with the first nibble after a loop |
| mem_rd_en | output | 1 | Sample memory read strobe |
| mem_addr | output | BYTE_AW | Sample memory byte address |
| mem_rdata | input | 8 | Sample memory read data, valid the cycle after the strobe |
| busy | output | 1 | Playback active |
| eos | output | 1 | Sticky end-of-sample flag |

## Verification
The hardest states to reach are the loop reload and the limit wrap, since both occur only after a long run of nibble requests from a programmed position. The bench keeps these runs short by using the shift-of-2 memory kind and small register values. It places the limit just past the start, so the wrap comes after eight nibbles. For the padded end it still runs one full 62-nibble sample in a shift-of-5 kind. Every nibble is compared against a computed memory pattern and the expected latency.

// File: rtl/adpcm_seq_pkg.sv
package adpcm_seq_pkg;

    localparam int DEF_REG_W    = 16;
    localparam int DEF_BYTE_AW  = 24;
    localparam int SHIFT_NARROW = 2;
    localparam int SHIFT_WIDE   = 5;

    typedef enum logic [1:0] {
        MEM_DRAM_X1 = 2'b00,
        MEM_ROM     = 2'b01,
        MEM_DRAM_X8 = 2'b10,
        MEM_ROM_ALT = 2'b11
    } mem_kind_e;

    typedef enum logic [2:0] {
        RSEL_START   = 3'd0,
        RSEL_END     = 3'd1,
        RSEL_LIMIT   = 3'd2,
        RSEL_MEMKIND = 3'd3,
        RSEL_CTRL    = 3'd4
    } reg_sel_e;

    localparam int CTL_GO    = 0;
    localparam int CTL_LOOP  = 1;
    localparam int CTL_ABORT = 2;

    typedef struct packed {
        logic go;
        logic loop;
        logic abort;
    } ctl_cmd_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_READY,
        SQ_FETCH,
        SQ_LATCH
    } seq_state_e;

    function automatic logic kind_is_wide(input mem_kind_e k);
        return (k != MEM_DRAM_X1);
    endfunction

endpackage

// File: rtl/adpcm_seq_regs.sv
module adpcm_seq_regs
    import adpcm_seq_pkg::*;
#(
    parameter int REG_W = DEF_REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] start_raw,
    output logic [REG_W-1:0] end_raw,
    output logic [REG_W-1:0] limit_raw,
    output logic             limit_en,
    output mem_kind_e        mem_kind,
    output logic             cmd_stb,
    output ctl_cmd_t         cmd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_raw <= '0;
            end_raw   <= '0;
            limit_raw <= '0;
            limit_en  <= 1'b0;
            mem_kind  <= MEM_DRAM_X1;
        end else if (reg_wr) begin
            case (reg_sel)
                RSEL_START:   start_raw <= reg_wdata;
                RSEL_END:     end_raw   <= reg_wdata;
                RSEL_LIMIT: begin
                    limit_raw <= reg_wdata;
                    limit_en  <= 1'b1;
                end
                RSEL_MEMKIND: mem_kind <= mem_kind_e'(reg_wdata[1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        cmd_stb   = reg_wr && (reg_sel == RSEL_CTRL);
        cmd.go    = reg_wdata[CTL_GO];
        cmd.loop  = reg_wdata[CTL_LOOP];
        cmd.abort = reg_wdata[CTL_ABORT];
    end

endmodule

// File: rtl/adpcm_seq_scaler.sv
module adpcm_seq_scaler
    import adpcm_seq_pkg::*;
#(
    parameter int REG_W   = DEF_REG_W,
    parameter int BYTE_AW = DEF_BYTE_AW,
    localparam int NIB_AW = BYTE_AW + 1
) (
    input  logic [REG_W-1:0]  start_raw,
    input  logic [REG_W-1:0]  end_raw,
    input  logic [REG_W-1:0]  limit_raw,
    input  logic              limit_en,
    input  mem_kind_e         mem_kind,
    output logic [NIB_AW-1:0] start_n,
    output logic [NIB_AW-1:0] end_n,
    output logic [NIB_AW-1:0] limit_n
);

    localparam int N_VARIANT = 2;

    logic [BYTE_AW-1:0] s_b [N_VARIANT];
    logic [BYTE_AW-1:0] e_b [N_VARIANT];
    logic [BYTE_AW-1:0] l_b [N_VARIANT];
    logic               wide;

    for (genvar g = 0; g < N_VARIANT; g++) begin : g_shift
        localparam int SH = (g == 0) ? SHIFT_NARROW : SHIFT_WIDE;
        localparam logic [BYTE_AW-1:0] PAD = BYTE_AW'((1 << SH) - 1);
        assign s_b[g] = BYTE_AW'(start_raw) << SH;
        assign e_b[g] = (BYTE_AW'(end_raw) << SH) | PAD;
        assign l_b[g] = BYTE_AW'(limit_raw) << SH;
    end

    always_comb begin
        wide    = kind_is_wide(mem_kind);
        start_n = {s_b[wide], 1'b0};
        end_n   = {e_b[wide], 1'b0};
        limit_n = limit_en ? {l_b[wide], 1'b0} : {{BYTE_AW{1'b1}}, 1'b0};
    end

endmodule

// File: rtl/adpcm_seq_walker.sv
module adpcm_seq_walker
    import adpcm_seq_pkg::*;
#(
    parameter int BYTE_AW = DEF_BYTE_AW,
    localparam int NIB_AW = BYTE_AW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_stb,
    input  ctl_cmd_t           cmd,
    input  logic [NIB_AW-1:0]  start_n,
    input  logic [NIB_AW-1:0]  end_n,
    input  logic [NIB_AW-1:0]  limit_n,
    input  logic               nib_req,
    input  logic [7:0]         mem_rdata,
    output logic               mem_rd_en,
    output logic [BYTE_AW-1:0] mem_addr,
    output logic               nib_valid,
    output logic [3:0]         nib_data,
    output logic               nib_restart,
    output logic               busy,
    output logic               eos
);

    seq_state_e         state;
    logic [NIB_AW-1:0]  pos_q;
    logic [BYTE_AW-1:0] rd_addr_q;
    logic [7:0]         held_q;
    logic               loop_q;
    logic               restart_pend;

    logic [NIB_AW-1:0]  wrapped;
    logic               at_end;
    logic [NIB_AW-1:0]  next_pos;

    always_comb begin
        wrapped  = (pos_q == limit_n) ? '0 : pos_q;
        at_end   = (wrapped == end_n);
        next_pos = (at_end && loop_q) ? start_n : wrapped;
    end

    always_ff @(posedge clk) begin
        nib_valid   <= 1'b0;
        nib_restart <= 1'b0;
        if (rst) begin
            state        <= SQ_IDLE;
            pos_q        <= '0;
            rd_addr_q    <= '0;
            held_q       <= '0;
            loop_q       <= 1'b0;
            restart_pend <= 1'b0;
            nib_data     <= '0;
            busy         <= 1'b0;
            eos          <= 1'b0;
        end else if (cmd_stb && cmd.abort) begin
            state        <= SQ_IDLE;
            busy         <= 1'b0;
            loop_q       <= 1'b0;
            restart_pend <= 1'b0;
        end else if (cmd_stb && cmd.go) begin
            state        <= SQ_READY;
            busy         <= 1'b1;
            eos          <= 1'b0;
            loop_q       <= cmd.loop;
            pos_q        <= start_n;
            restart_pend <= 1'b0;
        end else begin
            if (cmd_stb) begin
                loop_q <= cmd.loop;
            end
            case (state)
                SQ_READY: begin
                    if (nib_req) begin
                        if (at_end && !loop_q) begin
                            eos   <= 1'b1;
                            busy  <= 1'b0;
                            state <= SQ_IDLE;
                        end else if (!next_pos[0]) begin
                            restart_pend <= at_end;
                            rd_addr_q    <= next_pos[NIB_AW-1:1];
                            pos_q        <= next_pos + NIB_AW'(1);
                            state        <= SQ_FETCH;
                        end else begin
                            nib_data    <= held_q[3:0];
                            nib_valid   <= 1'b1;
                            nib_restart <= at_end;
                            pos_q       <= next_pos + NIB_AW'(1);
                        end
                    end
                end
                SQ_FETCH: state <= SQ_LATCH;
                SQ_LATCH: begin
                    held_q       <= mem_rdata;
                    nib_data     <= mem_rdata[7:4];
                    nib_valid    <= 1'b1;
                    nib_restart  <= restart_pend;
                    restart_pend <= 1'b0;
                    state        <= SQ_READY;
                end
                default: ;
            endcase
        end
    end

    assign mem_rd_en = (state == SQ_FETCH);
    assign mem_addr  = rd_addr_q;

endmodule

// File: rtl/adpcm_seq_top.sv
module adpcm_seq_top
    import adpcm_seq_pkg::*;
#(
    parameter int REG_W   = DEF_REG_W,
    parameter int BYTE_AW = DEF_BYTE_AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [2:0]         reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic               nib_req,
    output logic               nib_valid,
    output logic [3:0]         nib_data,
    output logic               nib_restart,
    output logic               mem_rd_en,
    output logic [BYTE_AW-1:0] mem_addr,
    input  logic [7:0]         mem_rdata,
    output logic               busy,
    output logic               eos
);

    localparam int NIB_AW = BYTE_AW + 1;

    logic [REG_W-1:0]  start_raw, end_raw, limit_raw;
    logic              limit_en;
    mem_kind_e         mem_kind;
    logic              cmd_stb;
    ctl_cmd_t          cmd;
    logic [NIB_AW-1:0] start_n, end_n, limit_n;

    adpcm_seq_regs #(.REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .start_raw (start_raw),
        .end_raw   (end_raw),
        .limit_raw (limit_raw),
        .limit_en  (limit_en),
        .mem_kind  (mem_kind),
        .cmd_stb   (cmd_stb),
        .cmd       (cmd)
    );

    adpcm_seq_scaler #(.REG_W(REG_W), .BYTE_AW(BYTE_AW)) u_scale (
        .start_raw (start_raw),
        .end_raw   (end_raw),
        .limit_raw (limit_raw),
        .limit_en  (limit_en),
        .mem_kind  (mem_kind),
        .start_n   (start_n),
        .end_n     (end_n),
        .limit_n   (limit_n)
    );

    adpcm_seq_walker #(.BYTE_AW(BYTE_AW)) u_walk (
        .clk         (clk),
        .rst         (rst),
        .cmd_stb     (cmd_stb),
        .cmd         (cmd),
        .start_n     (start_n),
        .end_n       (end_n),
        .limit_n     (limit_n),
        .nib_req     (nib_req),
        .mem_rdata   (mem_rdata),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .nib_valid   (nib_valid),
        .nib_data    (nib_data),
        .nib_restart (nib_restart),
        .busy        (busy),
        .eos         (eos)
    );

endmodule

// File: rtl/adpcm_seq_chk.sv
module adpcm_seq_chk (
    input logic clk,
    input logic rst,
    input logic nib_valid,
    input logic nib_restart,
    input logic mem_rd_en,
    input logic busy,
    input logic eos
);

    a_r4_valid_while_busy: assert property (@(posedge clk) disable iff (rst)
        nib_valid |-> busy);

    a_r5_read_single_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    a_r5_valid_single_cycle: assert property (@(posedge clk) disable iff (rst)
        nib_valid |=> !nib_valid);

    a_r6_eos_drops_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(eos) |-> !busy);

    a_r7_restart_has_nibble: assert property (@(posedge clk) disable iff (rst)
        nib_restart |-> nib_valid);

    a_r10_start_clears_eos: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !eos);

    a_r11_read_needs_busy: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> busy);

endmodule

bind adpcm_seq_top adpcm_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .nib_valid   (nib_valid),
    .nib_restart (nib_restart),
    .mem_rd_en   (mem_rd_en),
    .busy        (busy),
    .eos         (eos)
);

// File: tb/sim_adpcm_seq_top.sv
module sim_adpcm_seq_top;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst;
    logic        reg_wr;
    logic [2:0]  reg_sel;
    logic [15:0] reg_wdata;
    logic        nib_req;
    logic        nib_valid;
    logic [3:0]  nib_data;
    logic        nib_restart;
    logic        mem_rd_en;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        busy;
    logic        eos;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    adpcm_seq_top u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .nib_req(nib_req), .nib_valid(nib_valid),
        .nib_data(nib_data), .nib_restart(nib_restart), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .eos(eos)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input logic [23:0] a);
        return (a[7:0] * 8'd13) + 8'd5 + a[15:8];
    endfunction

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= pat(mem_addr);
    end

    task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic req_nib(output logic got, output logic [3:0] d, output logic rs,
                           output int lat, output logic rd, output logic [23:0] ra);
        got = 0; d = 0; rs = 0; lat = 0; rd = 0; ra = 0;
        @(negedge clk); nib_req = 1'b1;
        @(negedge clk); nib_req = 1'b0;
        for (int i = 1; i <= 6 && !got; i++) begin
            if (mem_rd_en) begin rd = 1; ra = mem_addr; end
            if (nib_valid) begin got = 1; d = nib_data; rs = nib_restart; lat = i; end
            else @(negedge clk);
        end
    endtask

    task automatic expect_run(input string tag, input int first_nib, input int count,
                              input logic first_rs);
        for (int k = 0; k < count; k++) begin
            int n; logic [7:0] b; logic got, rs, rd; logic [3:0] d; int lat; logic [23:0] ra;
            n = first_nib + k;
            b = pat(24'(n >> 1));
            req_nib(got, d, rs, lat, rd, ra);
            chk($sformatf("R4 %s valid nib %0d", tag, n), got, 1);
            chk($sformatf("R4 %s data nib %0d", tag, n), d, (n % 2 == 0) ? b[7:4] : b[3:0]);
            chk($sformatf("R5 %s latency nib %0d", tag, n), lat, (n % 2 == 0) ? 3 : 1);
            chk($sformatf("R7 %s restart nib %0d", tag, n), rs, (k == 0) ? first_rs : 1'b0);
            if (n % 2 == 0) chk($sformatf("R2 %s byte addr nib %0d", tag, n), ra, n >> 1);
            else chk($sformatf("R4 %s no read odd nib %0d", tag, n), rd, 0);
        end
    endtask

    task automatic expect_stop(input string tag);
        logic got, rs, rd; logic [3:0] d; int lat; logic [23:0] ra;
        req_nib(got, d, rs, lat, rd, ra);
        chk({"R3 ", tag, " no nibble at end"}, got, 0);
        chk({"R6 ", tag, " eos set"}, eos, 1);
        chk({"R6 ", tag, " busy cleared"}, busy, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 eos", eos, 0);
        chk("R1 nib_valid", nib_valid, 0);
        chk("R1 mem_rd_en", mem_rd_en, 0);
    endtask

    task automatic t_idle_req();
        logic got, rs, rd; logic [3:0] d; int lat; logic [23:0] ra;
        req_nib(got, d, rs, lat, rd, ra);
        chk("R11 no nibble idle", got, 0);
        chk("R11 no read idle", rd, 0);
    endtask

    task automatic t_rom_play();
        wr(3'd3, 16'd1);
        wr(3'd0, 16'd1);
        wr(3'd1, 16'd1);
        wr(3'd4, 16'h0001);
        chk("R10 busy after go", busy, 1);
        chk("R10 eos low after go", eos, 0);
        expect_run("rom", 64, 62, 1'b0);
        expect_stop("rom");
    endtask

    task automatic t_dram1_play();
        wr(3'd3, 16'd0);
        wr(3'd0, 16'd3);
        wr(3'd1, 16'd4);
        wr(3'd4, 16'h0001);
        chk("R10 eos cleared by go", eos, 0);
        expect_run("dram1", 24, 14, 1'b0);
        expect_stop("dram1");
    endtask

    task automatic t_dram8_abort();
        logic got, rs, rd; logic [3:0] d; int lat; logic [23:0] ra;
        wr(3'd3, 16'd2);
        wr(3'd0, 16'd2);
        wr(3'd1, 16'd9);
        wr(3'd4, 16'h0001);
        chk("R10 eos cleared again", eos, 0);
        expect_run("dram8", 128, 3, 1'b0);
        wr(3'd4, 16'h0005);
        chk("R9 busy cleared by abort", busy, 0);
        req_nib(got, d, rs, lat, rd, ra);
        chk("R9 no nibble after abort", got, 0);
        chk("R9 no read after abort", rd, 0);
    endtask

    task automatic t_repeat();
        wr(3'd3, 16'd0);
        wr(3'd0, 16'd0);
        wr(3'd1, 16'd1);
        wr(3'd4, 16'h0003);
        expect_run("loop", 0, 14, 1'b0);
        expect_run("loop reload", 0, 3, 1'b1);
        chk("R7 busy after reload", busy, 1);
        chk("R7 eos low after reload", eos, 0);
    endtask

    task automatic t_limit();
        logic got, rs, rd; logic [3:0] d; int lat; logic [23:0] ra;
        wr(3'd3, 16'd0);
        wr(3'd2, 16'd2);
        wr(3'd0, 16'd1);
        wr(3'd1, 16'hFFFF);
        wr(3'd4, 16'h0001);
        expect_run("limit", 8, 8, 1'b0);
        req_nib(got, d, rs, lat, rd, ra);
        chk("R8 wrap nibble valid", got, 1);
        chk("R8 wrap fetch byte 0", ra, 0);
        chk("R8 wrap data", d, pat(24'd0) >> 4);
        expect_run("after wrap", 1, 4, 1'b0);
    endtask

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0; nib_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_req();
        t_rom_play();
        t_dram1_play();
        t_dram8_abort();
        t_repeat();
        t_limit();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule